// File: doc/BRIEF.md
# Region-Based Memory Access Filter

This block sits in front of a small memory protection unit and decides, for each access request, whether it may proceed. A request carries a 16-bit address, an access kind (read, write or execute) and a privilege flag. The filter compares the address against three programmed regions, looks up each matching region's permission bits for that kind and privilege, and returns a grant or deny answer, together with the set of regions that matched, on the clock edge after the request strobe.

Regions may overlap, and the way overlaps are settled is fixed at build time. In priority mode only the matching region with the smallest index is consulted. In agreement mode every matching region must permit the access. Either way an address outside every region is denied, so a region added by less trusted software cannot widen another region's rights through a badly resolved overlap. The range and permission words come in as flat vectors from a separate configuration block; the filter holds no configuration of its own.

Top module: `mem_access_filter`

## Requirements
- R1: After reset, rspValid, rspGrant and rspHit are all zero.
- R2: rspValid is high in the cycle after a cycle with reqValid high, and low in the cycle after a cycle with reqValid low.
- R3: Region i covers an address A when its size (range word bits 31:16) is nonzero and base <= A < base + size, where base is range word bits 15:0 and the sum is taken 17 bits wide, so a region passing 0xFFFF stops at 0xFFFF and never wraps to low addresses; rspHit bit i reports this for the captured request.
- R4: A region with a size field of zero matches no address.
- R5: A request whose address is in no region is denied.
- R6: Permission bit positions in a policy word are: 0 non-privileged read, 1 non-privileged write, 2 non-privileged execute, 3 privileged read, 4 privileged write, 5 privileged execute; a one permits, a zero forbids, and bits 31:6 have no effect.
- R7: With ALL_AGREE = 0, when several regions match, the grant equals the permission bit of the matching region with the smallest index.
- R8: With ALL_AGREE = 1, the grant is given only when at least one region matches and every matching region permits the access.
- R9: Access kind is encoded 0 read, 1 write, 2 execute on reqKind; the code 3 is always denied.
- R10: In a cycle without reqValid, rspGrant and rspHit keep the values of the last answered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 16 | Address to check |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| reqPriv | input | 1 | 1 for privileged software, 0 otherwise |
| rangeVec | input | 96 | Range words, region i in bits 32*i+31:32*i (size in upper half, base in lower half) |
| policyVec | input | 96 | Permission words, region i in bits 32*i+31:32*i |
| rspValid | output | 1 | Answer valid, one cycle after reqValid |
| rspGrant | output | 1 | 1 when the captured request is permitted |
| rspHit | output | 3 | Bit i set when region i matched the captured request |

## Verification
The hardest situation to reach is a three-way overlap in which the regions disagree, combined with a region clipped at the top of the address space and a region of size zero, because only then do the two overlap rules and the clipping give different answers. The bench programs such layouts directly on the configuration vectors, with deliberate junk in the unused upper policy bits, and runs one instance of each mode side by side on the same request stream. Addresses sweep the space in coarse steps plus every region edge and the addresses one below and one above, with every access kind and privilege, so each overlap boundary is crossed in both directions.

// File: rtl/maf_pkg.sv
package maf_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_t;

  localparam int PERM_W = 6;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;
  } maf_strobe_t;

  // pick the permission bit for one kind/privilege pair
  function automatic logic permitBit(input logic [PERM_W-1:0] perms,
                                     input logic [1:0] kind,
                                     input logic priv);
    int idx;
    if (kind == KIND_RSVD) return 1'b0;
    idx = (priv ? 3 : 0) + int'(kind);
    return perms[idx];
  endfunction

endpackage

// File: rtl/maf_ctrl.sv
module maf_ctrl
  import maf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output maf_strobe_t strobe,
  output logic        rspValid
);

  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2

endmodule

// File: rtl/maf_datapath.sv
module maf_datapath
  import maf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_REG   = 3,
  parameter int RANGE_W   = 32,
  parameter int POL_W     = 32,
  parameter bit ALL_AGREE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  maf_strobe_t              strobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               kind,
  input  logic                     priv,
  input  logic [NUM_REG*RANGE_W-1:0] rangeVec,
  input  logic [NUM_REG*POL_W-1:0] policyVec,
  output logic                     grantQ,
  output logic [NUM_REG-1:0]       hitQ
);

  localparam int SIZE_LSB = ADDR_W;
  localparam int LIM_W    = ADDR_W + 1;
  localparam int SPARE_W  = POL_W - PERM_W;

  logic [NUM_REG-1:0] hitComb;
  logic [NUM_REG-1:0] allowComb;
  logic               grantComb;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_region
    logic [ADDR_W-1:0] baseF;
    logic [ADDR_W-1:0] sizeF;
    logic [LIM_W-1:0]  limitF;
    logic              unusedPolicyHi;

    assign baseF  = rangeVec[g*RANGE_W +: ADDR_W];
    assign sizeF  = rangeVec[g*RANGE_W + SIZE_LSB +: ADDR_W];
    // 17-bit end so a region past the top is clipped, not wrapped
    assign limitF = {1'b0, baseF} + {1'b0, sizeF};

    assign hitComb[g] = (sizeF != '0) && (addr >= baseF) &&
                        ({1'b0, addr} < limitF);

    assign allowComb[g] = permitBit(policyVec[g*POL_W +: PERM_W], kind, priv);
    assign unusedPolicyHi = ^policyVec[g*POL_W + PERM_W +: SPARE_W];

    AST_ZERO_SIZE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (sizeF == '0) |-> !hitComb[g]); // R4
  end

  if (ALL_AGREE) begin : g_agree
    always_comb begin
      grantComb = (|hitComb) && (&(allowComb | ~hitComb));
    end

    AST_VETO_DENIES: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && |(hitComb & ~allowComb)) |=> !grantQ); // R8
  end else begin : g_priority
    always_comb begin
      logic found;
      found     = 1'b0;
      grantComb = 1'b0;
      for (int i = 0; i < NUM_REG; i++) begin
        if (hitComb[i] && !found) begin
          grantComb = allowComb[i];
          found     = 1'b1;
        end
      end
    end

    AST_LOWEST_DECIDES: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && hitComb[0]) |=> (grantQ == $past(allowComb[0]))); // R7
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      hitQ   <= '0;
    end else if (strobe.capture) begin
      grantQ <= grantComb;
      hitQ   <= hitComb;
    end
  end

  AST_NO_HIT_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitComb == '0) |=> !grantQ); // R5

  AST_RSVD_KIND_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && kind == 2'd3) |=> !grantQ); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(grantQ) && $stable(hitQ))); // R10

endmodule

// File: rtl/mem_access_filter.sv
module mem_access_filter
  import maf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_REG   = 3,
  parameter int RANGE_W   = 32,
  parameter int POL_W     = 32,
  parameter bit ALL_AGREE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [1:0]                 reqKind,
  input  logic                       reqPriv,
  input  logic [NUM_REG*RANGE_W-1:0] rangeVec,
  input  logic [NUM_REG*POL_W-1:0]   policyVec,
  output logic                       rspValid,
  output logic                       rspGrant,
  output logic [NUM_REG-1:0]         rspHit
);

  maf_strobe_t strobe;

  maf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  maf_datapath #(
    .ADDR_W    (ADDR_W),
    .NUM_REG   (NUM_REG),
    .RANGE_W   (RANGE_W),
    .POL_W     (POL_W),
    .ALL_AGREE (ALL_AGREE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (reqAddr),
    .kind      (reqKind),
    .priv      (reqPriv),
    .rangeVec  (rangeVec),
    .policyVec (policyVec),
    .grantQ    (rspGrant),
    .hitQ      (rspHit)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspGrant) |-> rspValid); // R1

endmodule

// File: tb/mem_access_filter_bench.sv
`timescale 1ns/1ps
module mem_access_filter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqPriv = 1'b0;
  logic [95:0] rangeVec = '0;
  logic [95:0] policyVec = '0;

  logic       vPri, gPri, vAll, gAll;
  logic [2:0] hPri, hAll;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mem_access_filter #(.ALL_AGREE(1'b0)) u_mem_access_filter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqPriv(reqPriv), .rangeVec(rangeVec),
    .policyVec(policyVec), .rspValid(vPri), .rspGrant(gPri), .rspHit(hPri));

  mem_access_filter #(.ALL_AGREE(1'b1)) u_mem_access_filter_all (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqPriv(reqPriv), .rangeVec(rangeVec),
    .policyVec(policyVec), .rspValid(vAll), .rspGrant(gAll), .rspHit(hAll));

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (addr %h kind %0d priv %0d)",
               tag, what, act, exp, reqAddr, reqKind, reqPriv);
    end
  endtask

  task automatic setRegion(input int idx, input int base, input int size, input logic [31:0] pol);
    rangeVec[idx*32 +: 32]  = {size[15:0], base[15:0]};
    policyVec[idx*32 +: 32] = pol;
  endtask

  // reference model, from the requirements
  task automatic model(input int a, input int kind, input int priv,
                       output bit gPrio, output bit gAgree, output logic [2:0] hit);
    bit allow[3];
    bit found = 0;
    bit veto = 0;
    gPrio = 0;
    for (int i = 0; i < 3; i++) begin
      int b = int'(rangeVec[i*32 +: 16]);
      int s = int'(rangeVec[i*32+16 +: 16]);
      hit[i] = (s != 0) && (a >= b) && (a < b + s);
      allow[i] = (kind != 3) && policyVec[i*32 + priv*3 + kind];
      if (hit[i] && !found) begin gPrio = allow[i]; found = 1; end
      if (hit[i] && !allow[i]) veto = 1;
    end
    gAgree = found && !veto;
  endtask

  task automatic request(input int a, input int kind, input int priv);
    bit ep, ea;
    logic [2:0] eh;
    string tagP, tagA;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a[15:0];
    reqKind  = kind[1:0];
    reqPriv  = priv[0];
    model(a, kind, priv, ep, ea, eh);
    @(posedge clk);
    @(negedge clk);
    if (kind == 3)      begin tagP = "R9"; tagA = "R9"; end
    else if (eh == 0)   begin tagP = "R5"; tagA = "R5"; end
    else                begin tagP = "R6/R7"; tagA = "R6/R8"; end
    chk("R2", vPri, 1, "valid prio");
    chk("R2", vAll, 1, "valid agree");
    chk("R3", hPri, eh, "hit prio");
    chk("R3", hAll, eh, "hit agree");
    chk(tagP, gPri, ep, "grant prio");
    chk(tagA, gAll, ea, "grant agree");
  endtask

  task automatic idleCheck();
    logic g0, g1;
    logic [2:0] h0, h1;
    @(negedge clk);
    g0 = gPri; h0 = hPri; g1 = gAll; h1 = hAll;
    reqValid = 1'b0;
    reqAddr  = ~reqAddr;
    reqKind  = reqKind ^ 2'd1;
    @(posedge clk);
    @(negedge clk);
    chk("R2", vPri, 0, "idle valid");
    chk("R10", gPri, g0, "idle grant prio");
    chk("R10", hPri, h0, "idle hit prio");
    chk("R10", gAll, g1, "idle grant agree");
    chk("R10", hAll, h1, "idle hit agree");
  endtask

  task automatic sweep(input int edges[$]);
    for (int k = 0; k < 256; k++)
      for (int c = 0; c < 8; c++) request((k * 257) & 16'hFFFF, c % 4, c / 4);
    foreach (edges[e])
      for (int d = -1; d <= 1; d++)
        for (int c = 0; c < 8; c++) request((edges[e] + d) & 16'hFFFF, c % 4, c / 4);
    idleCheck();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", vPri, 0, "reset valid");
    chk("R1", gPri, 0, "reset grant");
    chk("R1", hPri, 0, "reset hit");
    chk("R1", hAll, 0, "reset hit agree");
    rstN = 1'b1;

    // three-way overlap, mixed policies, junk in bits 31:6 (R6)
    setRegion(0, 16'h1000, 16'h0100, 32'hFFFF_FFC8);
    setRegion(1, 16'h1080, 16'h0200, 32'h0000_003F);
    setRegion(2, 16'h1000, 16'h2000, 32'hAAAA_AA47);
    sweep('{32'h1000, 32'h1080, 32'h1100, 32'h1280, 32'h3000});

    // clipped top region, zero-size region (R4), small low region
    setRegion(0, 16'h0000, 16'h0000, 32'h0000_003F);
    setRegion(1, 16'h0000, 16'h0010, 32'h0000_0009);
    setRegion(2, 16'hFF00, 16'h0200, 32'h0000_0012);
    sweep('{32'h0010, 32'hFF00, 32'hFFFF, 32'h0000, 32'h00FF});

    // R4: every region empty, nothing matches
    setRegion(0, 16'h2000, 16'h0000, 32'hFFFF_FFFF);
    setRegion(1, 16'h0000, 16'h0000, 32'hFFFF_FFFF);
    setRegion(2, 16'h8000, 16'h0000, 32'hFFFF_FFFF);
    sweep('{32'h2000, 32'h8000});

    // identical regions that disagree: priority vs agreement
    setRegion(0, 16'h4000, 16'h1000, 32'h0000_0038);
    setRegion(1, 16'h4000, 16'h1000, 32'h0000_003F);
    setRegion(2, 16'h4800, 16'h1000, 32'h0000_0007);
    sweep('{32'h4000, 32'h4800, 32'h5000, 32'h5800});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule